// File: doc/BRIEF.md
# I2C Register-Access Mailbox Master

This block lets software reach a single-byte register of an external I2C device through four 16-bit host registers. Software first loads an extension register. Its low byte is the device register number, and its high byte is the byte to store. Software then writes a command word. The command word carries the 7-bit device address in bits 7:1 and a fixed opcode in bits 15:8. The block runs the whole transfer on the two-wire bus. While it does so, it shows a busy flag. When it finishes, it posts the outcome: a read-done flag, a sticky no-acknowledge flag and, for reads, the received byte.

The host side is a plain single-cycle write strobe with combinational read data. There is no stream interface and no back-pressure. A command that arrives while the block is busy is dropped without any effect, so software polls the busy flag before it issues the next command. The bus pins are open-drain: each output asks for its line to be pulled low, and a release lets the external pull-up raise it. The SCL timing comes from a prescaler parameter `CLK_DIV`. Each bit time is four quarters of `CLK_DIV` system clocks, and SCL is high for the middle two quarters.

Register offsets on `host_addr`:
- 0 is status: busy in bit 12, no-acknowledge error in bit 13 (write 1 to clear) and read-done in bit 14 (write 1 to clear). All other bits read 0.
- 1 is the write extension.
- 2 is the command register, which reads 0.
- 3 is the read extension, with the received byte in bits 15:8 and 0 in bits 7:0.

Top module: `i2c_mailbox_master`

## Requirements
- R1: After reset, status and read extension read 0x0000, and both `scl_oe` and `sda_oe` are 0 (lines released). The lines are also released whenever no transfer is in progress.
- R2: A command word with bits 15:8 = 0xC4 and bit 0 = 0 runs START, address+W, register byte, data byte, STOP. The register byte is extension bits 7:0 and the data byte is extension bits 15:8.
- R3: A command word with bits 15:8 = 0xC0 and bit 0 = 0 runs START, address+W, register byte, repeated START, address+R, one byte answered with NACK, STOP. When it ends, status bit 14 is 1 and the byte is in read-extension bits 15:8.
- R4: Status bit 12 reads 1 from the cycle after an accepted command until the transfer's outcome flags are visible, and reads 0 otherwise.
- R5: Status bit 14 clears only on a status write with bit 14 = 1. A status write with bit 14 = 0 leaves it set.
- R6: A command write that arrives while status bit 12 is 1 is ignored, even if the extension register was rewritten in the meantime.
- R7: A command word whose bits 15:8 are neither 0xC4 nor 0xC0, or whose bit 0 is 1, starts nothing.
- R8: A missing acknowledge ends the transfer with STOP and sets status bit 13, which stays set until a status write with bit 13 = 1. A failed read also sets bit 14. Busy then clears.
- R9: SDA moves while SCL is high only to form START, repeated START or STOP.
- R10: Every SCL high pulse inside a byte lasts exactly 2×`CLK_DIV` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Register write strobe, one cycle per write |
| host_addr | input | 2 | Register offset for reads and writes |
| host_wdata | input | 16 | Register write data |
| host_rdata | output | 16 | Register read data, combinational from `host_addr` |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The following properties are checked on every cycle:
- SDA only moves under a high SCL during START, repeated START and STOP phases.
- Busy only rises right after an accepted command.
- Both lines are released whenever the block is idle.
- A finished read always raises read-done, and a failed transfer always raises the error flag.

The bench's scenarios show what no single-cycle property can show. A device model acknowledges and stores or returns bytes on the bus, so the scenarios can confirm the following:
- The exact byte order reaches the device.
- A repeated START occurs inside reads.
- Commands issued while busy or with a bad opcode leave the device untouched.
- The write-one-to-clear flags behave correctly.
- The measured SCL high time matches the prescaler.

// File: rtl/i2cmb_pkg.sv
package i2cmb_pkg;

  // Bus-level operations the bit engine can run
  typedef enum logic [2:0] {
    OP_START,
    OP_RESTART,
    OP_STOP,
    OP_WRBYTE,
    OP_RDBYTE
  } bus_op_e;

  // Transaction sequencer states
  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_START,
    SQ_ADDR_W,
    SQ_REGNUM,
    SQ_WDATA,
    SQ_RESTART,
    SQ_ADDR_R,
    SQ_RDATA,
    SQ_STOP
  } seq_state_e;

  localparam logic [1:0] OFS_STATUS = 2'd0;
  localparam logic [1:0] OFS_WEXT   = 2'd1;
  localparam logic [1:0] OFS_CMD    = 2'd2;
  localparam logic [1:0] OFS_REXT   = 2'd3;

  localparam logic [7:0] OPC_WRITE = 8'hC4;
  localparam logic [7:0] OPC_READ  = 8'hC0;

  localparam int STS_BUSY  = 12;
  localparam int STS_NACK  = 13;
  localparam int STS_RDONE = 14;

endpackage

// File: rtl/i2cmb_bitgen.sv
module i2cmb_bitgen
  import i2cmb_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  bus_op_e    op,
  input  logic [7:0] tx_byte,
  input  logic       sda_in,
  output logic       done,
  output logic       ack_ok,
  output logic [7:0] rx_byte,
  output logic       scl_oe,
  output logic       sda_oe
);

  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(CLK_DIV - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sda_s;
  logic                   act;
  bus_op_e                op_q;
  logic [1:0]             qtr;
  logic [3:0]             bidx;
  logic [CW-1:0]          div;
  logic [7:0]             sh;
  logic                   is_byte;
  logic                   cur_b;
  logic                   nxt_b;

  // Pin levels {scl_lo, sda_lo} for each quarter of each operation
  function automatic logic [1:0] pins(bus_op_e o, logic [1:0] q, logic b);
    logic [1:0] r;
    case (o)
      OP_START:   r = (q == 2'd0) ? 2'b00 : (q == 2'd3) ? 2'b11 : 2'b01;
      OP_RESTART: r = (q == 2'd0) ? 2'b10 : (q == 2'd1) ? 2'b00 :
                      (q == 2'd2) ? 2'b01 : 2'b11;
      OP_STOP:    r = (q == 2'd0) ? 2'b11 : (q == 2'd1) ? 2'b01 : 2'b00;
      default:    r = {(q == 2'd0) || (q == 2'd3), ~b};
    endcase
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], sda_in};
  end
  assign sda_s = sync_q[SYNC_STAGES-1];

  assign is_byte = (op_q == OP_WRBYTE) || (op_q == OP_RDBYTE);
  assign cur_b   = (bidx == 4'd8) || (op_q != OP_WRBYTE) || sh[7];
  assign nxt_b   = (bidx == 4'd7) || (op_q != OP_WRBYTE) || sh[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act     <= 1'b0;
      op_q    <= OP_STOP;
      qtr     <= 2'd0;
      bidx    <= 4'd0;
      div     <= '0;
      sh      <= 8'h00;
      rx_byte <= 8'h00;
      ack_ok  <= 1'b0;
      done    <= 1'b0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!act) begin
        if (go) begin
          act  <= 1'b1;
          op_q <= op;
          qtr  <= 2'd0;
          bidx <= 4'd0;
          div  <= DIV_LAST;
          sh   <= tx_byte;
          {scl_oe, sda_oe} <= pins(op, 2'd0, (op != OP_WRBYTE) || tx_byte[7]);
        end
      end else if (div != '0) begin
        div <= div - 1'b1;
      end else begin
        div <= DIV_LAST;
        if (qtr == 2'd2 && is_byte) begin
          if (bidx != 4'd8) rx_byte <= {rx_byte[6:0], sda_s};
          else              ack_ok  <= ~sda_s;
        end
        if (qtr != 2'd3) begin
          qtr <= qtr + 2'd1;
          {scl_oe, sda_oe} <= pins(op_q, qtr + 2'd1, cur_b);
        end else if (is_byte && bidx != 4'd8) begin
          bidx <= bidx + 4'd1;
          sh   <= {sh[6:0], 1'b0};
          qtr  <= 2'd0;
          {scl_oe, sda_oe} <= pins(op_q, 2'd0, nxt_b);
        end else begin
          act  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R9: data may only move under a high clock during start/stop framing
  a_r9_sda_under_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(scl_oe) && !scl_oe && (sda_oe != $past(sda_oe)))
      |-> (op_q == OP_START || op_q == OP_RESTART || op_q == OP_STOP));

endmodule

// File: rtl/i2cmb_seq.sv
module i2cmb_seq
  import i2cmb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_go,
  input  logic       cmd_rd,
  input  logic [6:0] cmd_dev,
  input  logic [7:0] cmd_reg,
  input  logic [7:0] cmd_dat,
  input  logic       eng_done,
  input  logic       eng_ack,
  input  logic [7:0] eng_rx,
  output logic       eng_go,
  output bus_op_e    eng_op,
  output logic [7:0] eng_tx,
  output logic       busy,
  output logic       txn_end,
  output logic       txn_rd,
  output logic       txn_fail,
  output logic [7:0] txn_byte
);

  seq_state_e state;
  logic [6:0] dev_q;
  logic [7:0] reg_q;
  logic [7:0] dat_q;
  logic       kick;

  assign busy   = (state != SQ_IDLE);
  assign eng_go = kick;

  always_comb begin
    eng_op = OP_STOP;
    eng_tx = 8'h00;
    case (state)
      SQ_START:   eng_op = OP_START;
      SQ_ADDR_W:  begin eng_op = OP_WRBYTE; eng_tx = {dev_q, 1'b0}; end
      SQ_REGNUM:  begin eng_op = OP_WRBYTE; eng_tx = reg_q; end
      SQ_WDATA:   begin eng_op = OP_WRBYTE; eng_tx = dat_q; end
      SQ_RESTART: eng_op = OP_RESTART;
      SQ_ADDR_R:  begin eng_op = OP_WRBYTE; eng_tx = {dev_q, 1'b1}; end
      SQ_RDATA:   eng_op = OP_RDBYTE;
      default:    eng_op = OP_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      dev_q    <= 7'h00;
      reg_q    <= 8'h00;
      dat_q    <= 8'h00;
      kick     <= 1'b0;
      txn_end  <= 1'b0;
      txn_rd   <= 1'b0;
      txn_fail <= 1'b0;
      txn_byte <= 8'h00;
    end else begin
      kick    <= 1'b0;
      txn_end <= 1'b0;
      if (state == SQ_IDLE) begin
        if (cmd_go) begin
          dev_q    <= cmd_dev;
          reg_q    <= cmd_reg;
          dat_q    <= cmd_dat;
          txn_rd   <= cmd_rd;
          txn_fail <= 1'b0;
          state    <= SQ_START;
          kick     <= 1'b1;
        end
      end else if (eng_done) begin
        kick <= 1'b1;
        case (state)
          SQ_START: state <= SQ_ADDR_W;
          SQ_ADDR_W: begin
            if (!eng_ack) begin txn_fail <= 1'b1; state <= SQ_STOP; end
            else state <= SQ_REGNUM;
          end
          SQ_REGNUM: begin
            if (!eng_ack) begin txn_fail <= 1'b1; state <= SQ_STOP; end
            else state <= txn_rd ? SQ_RESTART : SQ_WDATA;
          end
          SQ_WDATA: begin
            if (!eng_ack) txn_fail <= 1'b1;
            state <= SQ_STOP;
          end
          SQ_RESTART: state <= SQ_ADDR_R;
          SQ_ADDR_R: begin
            if (!eng_ack) begin txn_fail <= 1'b1; state <= SQ_STOP; end
            else state <= SQ_RDATA;
          end
          SQ_RDATA: begin
            txn_byte <= eng_rx;
            state    <= SQ_STOP;
          end
          default: begin
            state   <= SQ_IDLE;
            kick    <= 1'b0;
            txn_end <= 1'b1;
          end
        endcase
      end
    end
  end

  // R4: the sequencer leaves idle only on an accepted command
  a_r4_busy_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_go));

  // R4: an accepted command always makes the block busy
  a_r4_cmd_makes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |=> busy);

endmodule

// File: rtl/i2cmb_regs.sv
module i2cmb_regs
  import i2cmb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [1:0]  host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  input  logic        busy,
  input  logic        txn_end,
  input  logic        txn_rd,
  input  logic        txn_fail,
  input  logic [7:0]  txn_byte,
  output logic        cmd_go,
  output logic        cmd_rd,
  output logic [6:0]  cmd_dev,
  output logic [7:0]  cmd_reg,
  output logic [7:0]  cmd_dat
);

  logic [15:0] wext_q;
  logic [7:0]  rbyte_q;
  logic        rdone_q;
  logic        nack_q;
  logic        busy_eff;
  logic        sts_wr;
  logic [7:0]  opc;

  // Busy stays visible until the outcome flags have landed
  assign busy_eff = busy | txn_end;
  assign sts_wr   = host_we && (host_addr == OFS_STATUS);
  assign opc      = host_wdata[15:8];

  assign cmd_go  = host_we && (host_addr == OFS_CMD) && !busy_eff &&
                   !host_wdata[0] && ((opc == OPC_WRITE) || (opc == OPC_READ));
  assign cmd_rd  = (opc == OPC_READ);
  assign cmd_dev = host_wdata[7:1];
  assign cmd_reg = wext_q[7:0];
  assign cmd_dat = wext_q[15:8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wext_q  <= 16'h0000;
      rbyte_q <= 8'h00;
      rdone_q <= 1'b0;
      nack_q  <= 1'b0;
    end else begin
      if (host_we && host_addr == OFS_WEXT) wext_q <= host_wdata;

      if (txn_end && txn_rd)                rdone_q <= 1'b1;
      else if (sts_wr && host_wdata[STS_RDONE]) rdone_q <= 1'b0;

      if (txn_end && txn_fail)              nack_q <= 1'b1;
      else if (sts_wr && host_wdata[STS_NACK])  nack_q <= 1'b0;

      if (txn_end && txn_rd && !txn_fail)   rbyte_q <= txn_byte;
    end
  end

  always_comb begin
    host_rdata = 16'h0000;
    case (host_addr)
      OFS_STATUS: begin
        host_rdata[STS_BUSY]  = busy_eff;
        host_rdata[STS_NACK]  = nack_q;
        host_rdata[STS_RDONE] = rdone_q;
      end
      OFS_WEXT: host_rdata = wext_q;
      OFS_REXT: host_rdata = {rbyte_q, 8'h00};
      default:  host_rdata = 16'h0000;
    endcase
  end

  // R3: every finished read, good or failed, raises read-done
  a_r3_read_posts_done: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_end && txn_rd) |=> rdone_q);

  // R8: a failed transfer always leaves the error flag set
  a_r8_fail_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_end && txn_fail) |=> nack_q);

endmodule

// File: rtl/i2c_mailbox_master.sv
module i2c_mailbox_master
  import i2cmb_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [1:0]  host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_in
);

  logic       cmd_go;
  logic       cmd_rd;
  logic [6:0] cmd_dev;
  logic [7:0] cmd_reg;
  logic [7:0] cmd_dat;
  logic       eng_go;
  bus_op_e    eng_op;
  logic [7:0] eng_tx;
  logic       eng_done;
  logic       eng_ack;
  logic [7:0] eng_rx;
  logic       seq_busy;
  logic       txn_end;
  logic       txn_rd;
  logic       txn_fail;
  logic [7:0] txn_byte;

  i2cmb_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .busy       (seq_busy),
    .txn_end    (txn_end),
    .txn_rd     (txn_rd),
    .txn_fail   (txn_fail),
    .txn_byte   (txn_byte),
    .cmd_go     (cmd_go),
    .cmd_rd     (cmd_rd),
    .cmd_dev    (cmd_dev),
    .cmd_reg    (cmd_reg),
    .cmd_dat    (cmd_dat)
  );

  i2cmb_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_go   (cmd_go),
    .cmd_rd   (cmd_rd),
    .cmd_dev  (cmd_dev),
    .cmd_reg  (cmd_reg),
    .cmd_dat  (cmd_dat),
    .eng_done (eng_done),
    .eng_ack  (eng_ack),
    .eng_rx   (eng_rx),
    .eng_go   (eng_go),
    .eng_op   (eng_op),
    .eng_tx   (eng_tx),
    .busy     (seq_busy),
    .txn_end  (txn_end),
    .txn_rd   (txn_rd),
    .txn_fail (txn_fail),
    .txn_byte (txn_byte)
  );

  i2cmb_bitgen #(
    .CLK_DIV     (CLK_DIV),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_bitgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (eng_go),
    .op      (eng_op),
    .tx_byte (eng_tx),
    .sda_in  (sda_in),
    .done    (eng_done),
    .ack_ok  (eng_ack),
    .rx_byte (eng_rx),
    .scl_oe  (scl_oe),
    .sda_oe  (sda_oe)
  );

  // R1: with no transfer running, both lines are left to the pull-ups
  a_r1_idle_lines_free: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy |-> (!scl_oe && !sda_oe));

endmodule

// File: tb/test_i2c_mailbox_master.sv
module test_i2c_mailbox_master;

  localparam int DIV = 4;
  localparam logic [6:0] SLV = 7'h50;
  localparam logic [6:0] NOBODY = 7'h33;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [15:0] host_wdata = 16'h0;
  logic [15:0] host_rdata;
  logic        scl_oe;
  logic        sda_oe;
  logic        slv_lo = 1'b0;
  logic        scl_line;
  logic        sda_line;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | slv_lo);

  always #4 clk = ~clk;

  i2c_mailbox_master #(.CLK_DIV(DIV)) i_i2c_mailbox_master (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .sda_in     (sda_line)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- device model + scoreboard monitor ----------------
  logic [7:0]  mem [256];
  logic [15:0] exp_q [$];
  logic        p_scl = 1'b1, p_sda = 1'b1;
  logic        s_act = 1'b0, s_rdm = 1'b0, s_pend = 1'b0;
  int          s_bc = 0, s_bidx = 0;
  logic [7:0]  s_sh = 8'h0, s_ptr = 8'h0, s_tx = 8'h0;
  int          starts = 0, stops = 0, wr_cnt = 0;

  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_scl && scl_line && p_sda && !sda_line) begin
        s_act = 1; s_bc = 0; s_bidx = 0; s_rdm = 0; s_pend = 0; slv_lo = 0; starts++;
      end else if (p_scl && scl_line && !p_sda && sda_line) begin
        s_act = 0; slv_lo = 0; stops++;
      end else if (s_act && !p_scl && scl_line) begin
        if (s_bc < 8) s_sh = {s_sh[6:0], sda_line};
        if (s_bc < 9) s_bc++;
      end else if (s_act && p_scl && !scl_line) begin
        if (s_bc == 8 && !s_rdm) begin
          if (s_bidx == 0) begin
            if (s_sh[7:1] == SLV) begin slv_lo = 1; s_pend = s_sh[0]; end
            else s_act = 0;
          end else if (s_bidx == 1) begin
            s_ptr = s_sh; slv_lo = 1;
          end else begin
            mem[s_ptr] = s_sh; wr_cnt++; slv_lo = 1;
            if (exp_q.size() == 0) chk(0, "R2 unexpected device write", {s_ptr, s_sh}, 0);
            else begin
              logic [15:0] e;
              e = exp_q.pop_front();
              chk({s_ptr, s_sh} == e, "R2 device write reg/data", {s_ptr, s_sh}, e);
            end
          end
          s_bidx++;
        end else if (s_bc == 8 && s_rdm) begin
          slv_lo = 0;
        end else if (s_bc == 9) begin
          slv_lo = 0; s_bc = 0;
          if (s_pend && !s_rdm) begin s_rdm = 1; s_tx = mem[s_ptr]; slv_lo = ~s_tx[7]; end
        end else if (s_rdm && s_bc >= 1 && s_bc <= 7) begin
          slv_lo = ~s_tx[7 - s_bc];
        end
      end
    end
    p_scl = scl_line;
    p_sda = sda_line;
  end

  // SCL high-time monitor (R10)
  int hi_cnt = 0, pulses = 0, bad_pulses = 0;
  bit rose = 0, framed = 0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  always @(negedge clk) begin
    if (scl_line) begin
      if (!m_scl) begin hi_cnt = 1; rose = 1; framed = 0; end
      else begin
        hi_cnt++;
        if (sda_line != m_sda) framed = 1;
      end
    end else if (m_scl) begin
      if (rose && !framed) begin
        pulses++;
        if (hi_cnt != 2 * DIV) bad_pulses++;
      end
      rose = 0;
    end
    m_scl = scl_line;
    m_sda = sda_line;
  end

  // ---------------- host driver tasks ----------------
  int exp_starts = 0, exp_stops = 0;

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd_reg(2'd0, s);
      if (!s[12]) return;
    end
    chk(0, "R4 busy never cleared", 1, 0);
  endtask

  task automatic do_write(input logic [6:0] dev, input logic [7:0] r, input logic [7:0] d);
    if (dev == SLV) exp_q.push_back({r, d});
    exp_starts++; exp_stops++;
    wr_reg(2'd1, {d, r});
    wr_reg(2'd2, 16'hC400 | {8'h00, dev, 1'b0});
  endtask

  task automatic do_read(input logic [6:0] dev, input logic [7:0] r);
    exp_starts += (dev == SLV) ? 2 : 1; exp_stops++;
    wr_reg(2'd0, 16'h4000);
    wr_reg(2'd1, {8'h00, r});
    wr_reg(2'd2, 16'hC000 | {8'h00, dev, 1'b0});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int wc;
    repeat (4) @(negedge clk);
    chk(!scl_oe && !sda_oe, "R1 lines released in reset", {scl_oe, sda_oe}, 0);
    rst_n = 1'b1;
    rd_reg(2'd0, v); chk(v == 16'h0, "R1 status after reset", v, 0);
    rd_reg(2'd3, v); chk(v == 16'h0, "R1 read extension after reset", v, 0);

    // R2: register writes
    do_write(SLV, 8'h12, 8'hA5);
    rd_reg(2'd0, v); chk(v[12], "R4 busy after command", v, 16'h1000);
    wait_idle();
    rd_reg(2'd0, v); chk(v == 16'h0, "R2 status after write", v, 0);
    chk(mem[8'h12] == 8'hA5, "R2 device register 0x12", mem[8'h12], 8'hA5);
    chk(!scl_oe && !sda_oe, "R1 lines released when idle", {scl_oe, sda_oe}, 0);
    do_write(SLV, 8'h34, 8'h5A);
    wait_idle();
    chk(mem[8'h34] == 8'h5A, "R2 device register 0x34", mem[8'h34], 8'h5A);

    // R3: register reads with repeated start
    wc = starts;
    do_read(SLV, 8'h12);
    wait_idle();
    rd_reg(2'd0, v); chk(v == 16'h4000, "R3 read-done set", v, 16'h4000);
    rd_reg(2'd3, v); chk(v == 16'hA500, "R3 read byte 0x12", v, 16'hA500);
    chk(starts - wc == 2, "R3 repeated start seen", starts - wc, 2);
    do_read(SLV, 8'h34);
    wait_idle();
    rd_reg(2'd3, v); chk(v == 16'h5A00, "R3 read byte 0x34", v, 16'h5A00);

    // R5: write-one-to-clear of read-done
    wr_reg(2'd0, 16'h0000);
    rd_reg(2'd0, v); chk(v[14], "R5 zero write keeps read-done", v, 16'h4000);
    wr_reg(2'd0, 16'h4000);
    rd_reg(2'd0, v); chk(v == 16'h0, "R5 one write clears read-done", v, 0);

    // R6: command during busy is dropped
    wc = wr_cnt;
    do_write(SLV, 8'h20, 8'h11);
    wr_reg(2'd1, 16'h2221);
    wr_reg(2'd2, 16'hC4A0);
    wait_idle();
    repeat (100) @(negedge clk);
    rd_reg(2'd0, v); chk(!v[12], "R6 no second transfer started", v, 0);
    chk(wr_cnt - wc == 1, "R6 single device write", wr_cnt - wc, 1);
    chk(mem[8'h21] == 8'h00, "R6 dropped data not stored", mem[8'h21], 0);

    // R7: bad command words
    wc = starts;
    wr_reg(2'd2, 16'hC5A0);
    rd_reg(2'd0, v); chk(!v[12], "R7 bad opcode ignored", v, 0);
    wr_reg(2'd2, 16'hC4A1);
    rd_reg(2'd0, v); chk(!v[12], "R7 bit0 set ignored", v, 0);
    wr_reg(2'd2, 16'h00A0);
    repeat (50) @(negedge clk);
    rd_reg(2'd0, v); chk(!v[12] && starts == wc, "R7 no bus activity", starts - wc, 0);

    // R8: missing acknowledge
    do_write(NOBODY, 8'h01, 8'h77);
    wait_idle();
    rd_reg(2'd0, v); chk(v == 16'h2000, "R8 write nack flags", v, 16'h2000);
    chk(!scl_oe && !sda_oe, "R8 lines released after abort", {scl_oe, sda_oe}, 0);
    wr_reg(2'd0, 16'h0000);
    rd_reg(2'd0, v); chk(v == 16'h2000, "R8 nack is sticky", v, 16'h2000);
    wr_reg(2'd0, 16'h2000);
    rd_reg(2'd0, v); chk(v == 16'h0, "R8 nack cleared", v, 0);
    do_read(NOBODY, 8'h01);
    wait_idle();
    rd_reg(2'd0, v); chk(v == 16'h6000, "R8 read nack sets read-done", v, 16'h6000);
    wr_reg(2'd0, 16'h6000);
    do_read(SLV, 8'h20);
    wait_idle();
    rd_reg(2'd3, v); chk(v == 16'h1100, "R8 recovery read", v, 16'h1100);

    // R9 / R10: framing and timing
    repeat (20) @(negedge clk);
    chk(starts == exp_starts, "R9 start/restart count", starts, exp_starts);
    chk(stops == exp_stops, "R9 stop count", stops, exp_stops);
    chk(pulses > 100 && bad_pulses == 0, "R10 SCL high time", bad_pulses, 0);
    chk(exp_q.size() == 0, "R2 all expected writes seen", exp_q.size(), 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule